// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU with Sticky Saturation

The block is a 32-bit integer arithmetic unit. Its datapath can be split into one 32-bit lane, two 16-bit lanes or four 8-bit lanes, and each lane computes its own result. The carry chain is cut wherever a lane begins, so a lane never takes a carry from its lower neighbour. Per lane it performs add, subtract, minimum, maximum, absolute value and negation. A single select bit chooses whether the lanes are read as signed or as unsigned numbers.

Two control operations turn a persistent saturation mode on and off. While the mode is on, every lane result that leaves the lane's range is clamped to the nearest representable value. While it is off, the result wraps. The mode stays as it is until the other control operation is issued, so a kernel can enable saturation once around a run of instructions instead of carrying a flag in each one. Every lane also reports an overflow flag, whether or not saturation is enabled.

An operation is presented on the operand and control inputs with `op_valid` high. Its result and flags appear on registered outputs after the next rising clock edge.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_mode` 00 selects one 32-bit lane. 01 selects two 16-bit lanes, with lane k in bits 16k+15:16k. 10 and 11 both select four 8-bit lanes, with lane k in bits 8k+7:8k. No carry or borrow crosses from one lane into the next.
- R2: `opcode` encodings are: 000 add, 001 subtract (a minus b), 010 minimum, 011 maximum, 100 absolute value of a, 101 negate a, 110 saturation on, 111 saturation off. `is_unsigned`=1 treats lanes as unsigned and 0 treats them as two's complement.
- R3: When `op_valid` is high at a rising edge, `result` and `lane_ovf` load the outcome of that operation at that edge. The two saturation control codes load 0 into both outputs. While `op_valid` is low, the outputs and the saturation mode hold.
- R4: The saturation mode is cleared by reset, set by the saturation-on code and cleared by the saturation-off code. It applies to every later operation until it is changed. Reset also clears `result` and `lane_ovf`.
- R5: With saturation off, each lane result equals the exact result modulo 2^lane-width.
- R6: With saturation on, an out-of-range signed lane clamps to its most positive or most negative value. An out-of-range unsigned lane clamps to all-ones when the exact result is too large and to zero when it is below zero.
- R7: `lane_ovf[k]` is 1 exactly when lane k's exact result lies outside the lane's range, independent of the saturation mode. Bits for lanes that do not exist in the current mode are 0.
- R8: Minimum and maximum compare lanes as signed or unsigned according to `is_unsigned`, and they never flag overflow.
- R9: Signed absolute value returns the magnitude. The most negative lane value flags overflow and returns the most positive value with saturation on, or itself with saturation off. Unsigned absolute value returns the operand unchanged and never flags overflow.
- R10: Negate returns 0 minus a. In signed lanes, the most negative value behaves as in R9. In unsigned lanes, any non-zero operand flags overflow and gives 0 with saturation on, or the two's complement with saturation off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue the operation on the inputs at this edge |
| opcode | input | 3 | Operation code, see R2 |
| lane_mode | input | 2 | Lane partitioning, see R1 |
| is_unsigned | input | 1 | 1 for unsigned lanes, 0 for signed lanes |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Registered lane results |
| lane_ovf | output | 4 | Registered per-lane overflow flags, bit k for lane k |

## Verification
The hardest situation to reach is the saturated most-negative case of absolute value and negation in each lane width. It only matters while the sticky mode is on, and it has to be separated from the ordinary overflow of add and subtract. The directed tasks first issue the saturation-on code and then place idle cycles and unrelated operations before the corner operands, so the persistence of the mode is exercised as well. A long pseudo-random sequence then interleaves control codes with operands drawn mostly from lane-boundary byte patterns such as 00, 7F, 80 and FF. Every result is compared with a lane-by-lane model that works on exact wide integers.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int SLICE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [2:0]             opcode,
  input  logic [1:0]             lane_mode,
  input  logic                   is_unsigned,
  input  logic [4*SLICE_W-1:0]   a,
  input  logic [4*SLICE_W-1:0]   b,
  output logic [4*SLICE_W-1:0]   result,
  output logic [3:0]             lane_ovf
);
  localparam int NS   = 4;
  localparam int HALF = NS / 2;
  localparam int DW   = NS * SLICE_W;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_MIN  = 3'd2;
  localparam logic [2:0] OP_MAX  = 3'd3;
  localparam logic [2:0] OP_ABS  = 3'd4;
  localparam logic [2:0] OP_NEG  = 3'd5;
  localparam logic [2:0] OP_SON  = 3'd6;
  localparam logic [2:0] OP_SOFF = 3'd7;

  localparam logic [SLICE_W-1:0] ONES = '1;
  localparam logic [SLICE_W-1:0] MAXP = {1'b0, {(SLICE_W-1){1'b1}}};
  localparam logic [SLICE_W-1:0] MINN = {1'b1, {(SLICE_W-1){1'b0}}};

  logic sat_q;
  logic quad, dual;
  logic unary, minmax, subl;
  logic [DW-1:0] x, y, sum, res_c;
  logic [NS:0]   carry;
  logic [NS-1:0] sov, ovf_raw, lt, hi, ovf_eff, neg_take;
  logic [3:0]    ovf_c;

  assign quad   = lane_mode[1];
  assign dual   = (lane_mode == 2'b01);
  assign unary  = (opcode == OP_ABS) || (opcode == OP_NEG);
  assign minmax = (opcode == OP_MIN) || (opcode == OP_MAX);
  assign subl   = (opcode == OP_SUB) || unary || minmax;

  assign x        = unary ? '0 : a;
  assign y        = subl ? ~(unary ? a : b) : b;
  assign carry[0] = subl;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    localparam bit DSTART = (i % HALF) == 0;
    localparam bit DTOP   = (i % HALF) == HALF - 1;
    localparam int TD     = (i / HALF) * HALF + HALF - 1;
    logic             st, top, ci, xm, ym, sm;
    logic [1:0]       ti;
    logic [SLICE_W-1:0] xs, ys, as, bs, ss, clampv, arith, pick;

    assign xs = x[i*SLICE_W +: SLICE_W];
    assign ys = y[i*SLICE_W +: SLICE_W];
    assign as = a[i*SLICE_W +: SLICE_W];
    assign bs = b[i*SLICE_W +: SLICE_W];

    assign st  = (i == 0) | quad | (dual & DSTART);
    assign top = (i == NS - 1) | quad | (dual & DTOP);
    assign ci  = st ? subl : carry[i];
    assign {carry[i+1], ss} = {1'b0, xs} + {1'b0, ys} + {{SLICE_W{1'b0}}, ci};
    assign sum[i*SLICE_W +: SLICE_W] = ss;

    assign xm = xs[SLICE_W-1];
    assign ym = ys[SLICE_W-1];
    assign sm = ss[SLICE_W-1];
    assign sov[i]      = (xm == ym) & (sm != xm);
    assign ovf_raw[i]  = is_unsigned ? (carry[i+1] ^ subl) : sov[i];
    assign lt[i]       = is_unsigned ? ~carry[i+1] : (sm ^ sov[i]);
    assign hi[i]       = is_unsigned ? ~subl : ~xm;
    assign neg_take[i] = ~is_unsigned & as[SLICE_W-1];
    assign ovf_eff[i]  = minmax ? 1'b0 :
                         (opcode == OP_ABS) ? (neg_take[i] & sov[i]) : ovf_raw[i];

    assign ti = quad ? 2'(i) : dual ? 2'(TD) : 2'(NS - 1);

    assign clampv = hi[ti] ? ((top & ~is_unsigned) ? MAXP : ONES)
                           : ((top & ~is_unsigned) ? MINN : '0);
    assign arith  = (sat_q & ovf_eff[ti]) ? clampv : ss;
    assign pick   = ((opcode == OP_MIN) ? lt[ti] : ~lt[ti]) ? as : bs;

    assign res_c[i*SLICE_W +: SLICE_W] =
        minmax ? pick :
        ((opcode == OP_ABS) & ~neg_take[ti]) ? as : arith;
  end

  for (genvar k = 0; k < NS; k++) begin : g_flag
    if (k == 0) begin : g_l0
      assign ovf_c[k] = quad ? ovf_eff[0] : dual ? ovf_eff[HALF-1] : ovf_eff[NS-1];
    end else if (k < 2) begin : g_l1
      assign ovf_c[k] = quad ? ovf_eff[k] : dual ? ovf_eff[k*HALF+HALF-1] : 1'b0;
    end else begin : g_lq
      assign ovf_c[k] = quad & ovf_eff[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q    <= 1'b0;
      result   <= '0;
      lane_ovf <= '0;
    end else if (op_valid) begin
      if (opcode == OP_SON || opcode == OP_SOFF) begin
        sat_q    <= (opcode == OP_SON);
        result   <= '0;
        lane_ovf <= '0;
      end else begin
        result   <= res_c;
        lane_ovf <= ovf_c;
      end
    end
  end
endmodule

module simd_lane_alu_chk #(
  parameter int SLICE_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [2:0]           opcode,
  input logic [1:0]           lane_mode,
  input logic                 is_unsigned,
  input logic [4*SLICE_W-1:0] a,
  input logic [4*SLICE_W-1:0] b,
  input logic [4*SLICE_W-1:0] result,
  input logic [3:0]           lane_ovf,
  input logic                 sat_q
);
  assert_sat_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 3'd6) |=> sat_q);

  assert_sat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 3'd7) |=> !sat_q);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(lane_ovf) && $stable(sat_q)));

  assert_wrap_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sat_q && opcode == 3'd0 && lane_mode == 2'b00)
      |=> result == $past(a) + $past(b));

  assert_unsigned_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_q && opcode == 3'd0 && is_unsigned && lane_mode == 2'b00)
      |=> (lane_ovf[0] ? (result == '1) : (result == $past(a) + $past(b))));

  assert_absent_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lane_mode == 2'b00) |=> lane_ovf[3:1] == 3'b000);

  assert_minmax_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 3'd2 || opcode == 3'd3)) |=> lane_ovf == 4'b0000);

  assert_uneg_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_q && opcode == 3'd5 && is_unsigned && lane_mode == 2'b00)
      |=> result == '0);
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.SLICE_W(SLICE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .lane_mode(lane_mode), .is_unsigned(is_unsigned), .a(a), .b(b),
  .result(result), .lane_ovf(lane_ovf), .sat_q(sat_q)
);

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [2:0]  opcode = 0;
  logic [1:0]  lane_mode = 0;
  logic        is_unsigned = 0;
  logic [31:0] a = 0, b = 0;
  logic [31:0] result;
  logic [3:0]  lane_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit sat_m = 0;
  logic [31:0] rng = 32'h1234_5678;

  simd_lane_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .lane_mode(lane_mode), .is_unsigned(is_unsigned), .a(a), .b(b),
    .result(result), .lane_ovf(lane_ovf)
  );

  always #10 clk = ~clk;

  function automatic void model(input logic [2:0] op, input logic [1:0] md,
                                input bit uns, input bit sat,
                                input logic [31:0] x, input logic [31:0] y,
                                output logic [31:0] r, output logic [3:0] f);
    int n, w;
    longint va, vb, e, lo, hi;
    logic [63:0] mask;
    bit ov;
    n = (md == 2'b00) ? 1 : (md == 2'b01) ? 2 : 4;
    w = 32 / n;
    mask = (64'd1 << w) - 1;
    r = 0;
    f = 0;
    for (int l = 0; l < n; l++) begin
      va = longint'((64'(x) >> (l * w)) & mask);
      vb = longint'((64'(y) >> (l * w)) & mask);
      if (!uns) begin
        if (va >= (longint'(1) << (w - 1))) va -= longint'(1) << w;
        if (vb >= (longint'(1) << (w - 1))) vb -= longint'(1) << w;
      end
      lo = uns ? 0 : -(longint'(1) << (w - 1));
      hi = uns ? (longint'(1) << w) - 1 : (longint'(1) << (w - 1)) - 1;
      case (op)
        3'd0: e = va + vb;
        3'd1: e = va - vb;
        3'd2: e = (va < vb) ? va : vb;
        3'd3: e = (va > vb) ? va : vb;
        3'd4: e = (va < 0) ? -va : va;
        3'd5: e = -va;
        default: e = 0;
      endcase
      ov = (e < lo) || (e > hi);
      if (ov && sat) e = (e > hi) ? hi : lo;
      f[l] = ov;
      r = r | 32'((64'(e) & mask) << (l * w));
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic [3:0] ef);
    checks++;
    if (result !== er || lane_ovf !== ef) begin
      errors++;
      $display("FAIL %s result=%h ovf=%b expected result=%h ovf=%b",
               tag, result, lane_ovf, er, ef);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [1:0] md, input bit uns,
                     input logic [31:0] x, input logic [31:0] y, input string tag);
    logic [31:0] er;
    logic [3:0] ef;
    @(negedge clk);
    op_valid = 1; opcode = op; lane_mode = md; is_unsigned = uns; a = x; b = y;
    if (op == 3'd6 || op == 3'd7) begin
      er = 0; ef = 0;
    end else begin
      model(op, md, uns, sat_m, x, y, er, ef);
    end
    @(negedge clk);
    op_valid = 0;
    if (op == 3'd6) sat_m = 1;
    if (op == 3'd7) sat_m = 0;
    check(tag, er, ef);
  endtask

  task automatic expect_val(input logic [31:0] er, input logic [3:0] ef, input string tag);
    check(tag, er, ef);
  endtask

  task automatic t_reset;
    expect_val(32'h0, 4'h0, "R4 reset outputs");
    run(3'd0, 2'b10, 0, 32'h0000_007F, 32'h0000_0001, "R4 R5 default wrap");
    expect_val(32'h0000_0080, 4'b0001, "R4 R7 default wrap value");
  endtask

  task automatic t_lanes;
    run(3'd0, 2'b00, 1, 32'h0000_00FF, 32'h0000_0001, "R1 carry crosses bytes in single");
    expect_val(32'h0000_0100, 4'h0, "R1 single value");
    run(3'd0, 2'b10, 1, 32'h0000_00FF, 32'h0000_0001, "R1 carry cut in quad");
    expect_val(32'h0000_0000, 4'b0001, "R1 R7 quad value");
    run(3'd0, 2'b01, 0, 32'h7FFF_FFFF, 32'h0001_0001, "R1 R5 dual signed");
    expect_val(32'h8000_0000, 4'b0010, "R7 dual flag lane1");
    run(3'd1, 2'b11, 0, 32'h0000_0000, 32'h0101_0101, "R1 mode 11 as quad borrow cut");
    expect_val(32'hFFFF_FFFF, 4'h0, "R1 borrow cut value");
    run(3'd1, 2'b10, 1, 32'h0000_0000, 32'h0100_0001, "R5 R7 unsigned borrow wrap");
  endtask

  task automatic t_sat;
    run(3'd6, 2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 sat-on clears outputs");
    @(negedge clk); @(negedge clk);
    run(3'd2, 2'b10, 0, 32'h1234_5678, 32'h8765_4321, "R8 intervening op");
    run(3'd0, 2'b10, 0, 32'h7F80_0101, 32'h0180_FF01, "R6 R4 signed quad clamp");
    expect_val(32'h7F80_0002, 4'b1100, "R6 signed quad clamp value");
    run(3'd0, 2'b01, 1, 32'hFFF0_0010, 32'h0020_0010, "R6 unsigned dual clamp high");
    expect_val(32'hFFFF_0020, 4'b0010, "R6 unsigned dual value");
    run(3'd1, 2'b00, 1, 32'h0000_0005, 32'h0000_0009, "R6 unsigned clamp zero");
    run(3'd1, 2'b00, 0, 32'h8000_0000, 32'h0000_0001, "R6 signed single clamp low");
    expect_val(32'h8000_0000, 4'b0001, "R6 single clamp value");
    run(3'd7, 2'b00, 0, 32'h0, 32'h0, "R3 R4 sat-off");
    run(3'd1, 2'b00, 0, 32'h8000_0000, 32'h0000_0001, "R5 wrap after sat-off");
    expect_val(32'h7FFF_FFFF, 4'b0001, "R5 R7 wrap value");
  endtask

  task automatic t_minmax;
    run(3'd2, 2'b10, 0, 32'h80FF_7F01, 32'h7F01_80FF, "R8 signed min");
    expect_val(32'h80FF_80FF, 4'h0, "R8 signed min value");
    run(3'd2, 2'b10, 1, 32'h80FF_7F01, 32'h7F01_80FF, "R8 unsigned min");
    expect_val(32'h7F01_7F01, 4'h0, "R8 unsigned min value");
    run(3'd3, 2'b01, 0, 32'h8000_0001, 32'h7FFF_FFFF, "R8 signed max dual");
    run(3'd3, 2'b00, 1, 32'h8000_0000, 32'h7FFF_FFFF, "R8 unsigned max single");
    expect_val(32'h8000_0000, 4'h0, "R8 unsigned max value");
  endtask

  task automatic t_absneg;
    run(3'd4, 2'b10, 0, 32'h80FF_7F00, 32'h0, "R9 abs quad sat off");
    expect_val(32'h8001_7F00, 4'b1000, "R9 abs most negative wraps");
    run(3'd5, 2'b01, 0, 32'h8000_0001, 32'h0, "R10 neg dual sat off");
    expect_val(32'h8000_FFFF, 4'b0010, "R10 neg value");
    run(3'd4, 2'b10, 1, 32'h80FF_7F00, 32'h0, "R9 unsigned abs passthrough");
    expect_val(32'h80FF_7F00, 4'h0, "R9 unsigned abs value");
    run(3'd6, 2'b00, 0, 32'h0, 32'h0, "R4 sat-on again");
    @(negedge clk);
    run(3'd4, 2'b10, 0, 32'h80FF_7F00, 32'h0, "R9 abs quad sat on");
    expect_val(32'h7F01_7F00, 4'b1000, "R9 abs clamps most negative");
    run(3'd4, 2'b01, 0, 32'h8000_8001, 32'h0, "R9 abs dual sat on");
    run(3'd4, 2'b00, 0, 32'h8000_0000, 32'h0, "R9 abs single sat on");
    expect_val(32'h7FFF_FFFF, 4'b0001, "R9 single clamp value");
    run(3'd5, 2'b10, 0, 32'h8000_7F01, 32'h0, "R10 neg quad sat on");
    expect_val(32'h7F00_81FF, 4'b1000, "R10 neg clamp value");
    run(3'd5, 2'b10, 1, 32'h0000_0100, 32'h0, "R10 unsigned neg sat on");
    expect_val(32'h0000_0000, 4'b0010, "R10 unsigned neg clamp zero");
    run(3'd7, 2'b00, 0, 32'h0, 32'h0, "R4 sat-off again");
    run(3'd5, 2'b00, 1, 32'h0000_0001, 32'h0, "R10 unsigned neg wrap");
    expect_val(32'hFFFF_FFFF, 4'b0001, "R10 unsigned neg wrap value");
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [3:0] f0;
    run(3'd0, 2'b01, 0, 32'h1111_2222, 32'h3333_4444, "R3 load");
    r0 = result; f0 = lane_ovf;
    @(negedge clk);
    op_valid = 0; opcode = 3'd6; a = 32'hDEAD_BEEF; b = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    expect_val(r0, f0, "R3 hold while idle");
    opcode = 3'd0;
    run(3'd0, 2'b10, 0, 32'h0000_007F, 32'h0000_0001, "R3 R4 idle sat-on code ignored");
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  function automatic logic [31:0] pick_operand(input logic [31:0] r);
    logic [31:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'h7F; pats[2] = 8'h80; pats[3] = 8'hFF;
    if (r[31:30] == 2'b00) return r;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = pats[r[k*2 +: 2]] ^ {7'b0, r[8+k]};
    return v;
  endfunction

  task automatic t_random;
    logic [2:0] op;
    logic [31:0] x, y;
    for (int n = 0; n < 600; n++) begin
      rng = nxt(rng);
      op = (rng[4:0] == 5'd0) ? 3'd6 : (rng[4:0] == 5'd1) ? 3'd7 : 3'(rng[7:5] % 6);
      rng = nxt(rng); x = pick_operand(rng);
      rng = nxt(rng); y = pick_operand(rng);
      run(op, rng[1:0], rng[2], x, y, "R2 random sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_lanes;
    t_sat;
    t_minmax;
    t_absneg;
    t_hold;
    t_random;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule